// File: doc/BRIEF.md
# Counter Run Control with Halt and Stop

This block is a free-running counter whose progress is governed by two independent gates. The halt gate is the stronger one: out of reset the counter is halted, no events are accepted, and only a software write to the control register can release it. The stop gate is weaker: it can be set or cleared by software, set by a stop event pulse, and cleared by a start event pulse, but only while the block is not halted. The counter advances only when both gates are open.

Counting is paced by a prescaler that produces one step every (prescale + 1) running cycles. The counter either wraps from a programmed limit back to zero, or runs up to the limit and back down to zero, with an output flag marking the down phase. A clear bit in the control register zeros the count and the prescaler and forces the direction up. While halted, software may also drive a small bank of output pins directly; such writes have no effect while the counter is not halted. The block exposes an events-allowed flag so that neighbouring event logic knows when its events may fire.

Top module: `runctl_timer`

## Requirements
- R1: After reset the block is halted (`ev_allow` = 0), the stop gate is clear, `count` = 0, `dir_down` = 0, `out_pins` = 0, prescale = 0, the mode is wrap-around and the limit is all ones.
- R2: While halted, `ev_allow` is 0 and `count` and `dir_down` hold their values, except for a control write with the clear bit set.
- R3: The count changes only in cycles where both the registered halt and stop gates are clear; if stop is set when halt is released, nothing advances until a start event or a control write with stop = 0.
- R4: With prescale value P, a running counter takes one step every P+1 clock cycles; the prescaler wraps when its phase reaches or exceeds P.
- R5: While halted, start and stop event pulses have no effect on the stop gate; only a control write can release halt.
- R6: In wrap-around mode (bidirectional bit = 0) the count goes 0, 1, ... up to the limit L and then to 0; a count at or above L also goes to 0.
- R7: A write to the output register (address 2, bits [OUT_N-1:0] = pin levels) updates `out_pins` in the next cycle only if the block is halted at the time of the write; otherwise it is ignored.
- R8: In up/down mode (bidirectional bit = 1) the count goes up to L, then down to 0, then up again; `dir_down` is 1 from the first step below L until the step after reaching 0. With L = 0 the count stays 0 and the direction stays up.
- R9: When not halted, a stop event sets the stop gate and a start event clears it; if both arrive in the same cycle, stop wins; a control write in the same cycle overrides either event.
- R10: A control write with the clear bit set makes `count` = 0, `dir_down` = 0 and the prescaler phase 0 in the next cycle, taking priority over counting.
- R11: Register encoding: address 0 is control (bit 0 halt, bit 1 stop, bit 2 bidirectional, bit 3 clear, bits [15:8] prescale); address 1 is the limit (bits [CNT_W-1:0]); address 2 is the output register. Every write takes effect at the clock edge that samples `wr_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | DATA_W | Register write data |
| start_ev | input | 1 | Start event pulse, clears the stop gate |
| stop_ev | input | 1 | Stop event pulse, sets the stop gate |
| count | output | CNT_W | Current counter value |
| dir_down | output | 1 | High while the counter is in its down phase |
| ev_allow | output | 1 | High when events are allowed (not halted) |
| out_pins | output | OUT_N | Software-driven output levels |

## Verification
Directed sequences first hold the block halted while start events arrive, release halt with stop still set, then start it by event, separating the halt gate from the stop gate. Runs with prescale 0 and 2, limit 5 in wrap-around mode, and limits 3 and 0 in up/down mode tell the step pacing and the two turn-around rules apart. Coincident start and stop events, and an event coinciding with a control write, pin down the priority order, while output writes before and during halt show the write lock. A long seeded random phase then mixes sparse control, limit and output writes with event pulses and compares every cycle against a bench model.

// File: rtl/runctl_pkg.sv
package runctl_pkg;

    typedef enum logic [1:0] {
        ADR_CTRL  = 2'd0,
        ADR_LIMIT = 2'd1,
        ADR_OUT   = 2'd2
    } reg_addr_e;

    localparam int CB_HALT    = 0;
    localparam int CB_STOP    = 1;
    localparam int CB_BIDIR   = 2;
    localparam int CB_CLEAR   = 3;
    localparam int CB_PRE_LSB = 8;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

endpackage

// File: rtl/runctl_gate.sv
module runctl_gate
    import runctl_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              lim_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              start_ev,
    input  logic              stop_ev,
    output logic              halt,
    output logic              stop,
    output logic              bidir,
    output logic [PRE_W-1:0]  presc,
    output logic [CNT_W-1:0]  limit,
    output logic              clr_req,
    output logic              run
);

    typedef struct packed {
        logic             halt;
        logic             stop;
        logic             bidir;
        logic [PRE_W-1:0] presc;
        logic [CNT_W-1:0] limit;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            // software write overrides any event in the same cycle
            st_d.halt  = wr_data[CB_HALT];
            st_d.stop  = wr_data[CB_STOP];
            st_d.bidir = wr_data[CB_BIDIR];
            st_d.presc = wr_data[CB_PRE_LSB +: PRE_W];
        end else if (!st_q.halt) begin
            if (stop_ev) begin
                st_d.stop = 1'b1;
            end else if (start_ev) begin
                st_d.stop = 1'b0;
            end
        end
        if (lim_wr) begin
            st_d.limit = wr_data[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.halt  <= 1'b1;
            st_q.stop  <= 1'b0;
            st_q.bidir <= 1'b0;
            st_q.presc <= '0;
            st_q.limit <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign halt    = st_q.halt;
    assign stop    = st_q.stop;
    assign bidir   = st_q.bidir;
    assign presc   = st_q.presc;
    assign limit   = st_q.limit;
    assign clr_req = ctrl_wr & wr_data[CB_CLEAR];
    assign run     = ~st_q.halt & ~st_q.stop;

endmodule

// File: rtl/runctl_prescale.sv
module runctl_prescale #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [PRE_W-1:0] presc,
    output logic             tick
);

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic    wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.phase >= presc);
        if (clr) begin
            st_d.phase = '0;
        end else if (run) begin
            st_d.phase = wrap ? '0 : st_q.phase + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = run & ~clr & wrap;

endmodule

// File: rtl/runctl_counter.sv
module runctl_counter
    import runctl_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic             bidir,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             dir_down
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        cnt_dir_e         dir;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    at_top;
    logic    at_zero;

    always_comb begin
        st_d    = st_q;
        at_top  = (st_q.cnt >= limit);
        at_zero = (st_q.cnt == '0);
        if (clr) begin
            st_d.cnt = '0;
            st_d.dir = DIR_UP;
        end else if (tick) begin
            if (!bidir) begin
                st_d.dir = DIR_UP;
                st_d.cnt = at_top ? '0 : st_q.cnt + CNT_W'(1);
            end else if (st_q.dir == DIR_UP) begin
                if (!at_top) begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end else if (!at_zero) begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                    st_d.dir = DIR_DOWN;
                end
            end else begin
                if (!at_zero) begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end else begin
                    st_d.dir = DIR_UP;
                    st_d.cnt = (limit == '0) ? '0 : CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.dir <= DIR_UP;
        end else begin
            st_q <= st_d;
        end
    end

    assign count    = st_q.cnt;
    assign dir_down = (st_q.dir == DIR_DOWN);

endmodule

// File: rtl/runctl_outreg.sv
module runctl_outreg #(
    parameter int OUT_N  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              out_wr,
    input  logic              halt,
    input  logic [DATA_W-1:0] wr_data,
    output logic [OUT_N-1:0]  out_pins
);

    logic [OUT_N-1:0] pin_d, pin_q;
    logic             take;

    assign take = out_wr & halt;

    for (genvar i = 0; i < OUT_N; i++) begin : g_pin
        always_comb begin
            pin_d[i] = take ? wr_data[i] : pin_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= '0;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign out_pins = pin_q;

endmodule

// File: rtl/runctl_timer.sv
module runctl_timer
    import runctl_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 8,
    parameter int OUT_N  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              start_ev,
    input  logic              stop_ev,
    output logic [CNT_W-1:0]  count,
    output logic              dir_down,
    output logic              ev_allow,
    output logic [OUT_N-1:0]  out_pins
);

    logic             ctrl_wr, lim_wr, out_wr;
    logic             halt_w, stop_w, bidir_w, clr_w, run_w, tick_w;
    logic [PRE_W-1:0] presc_w;
    logic [CNT_W-1:0] limit_w;

    assign ctrl_wr = wr_en & (wr_addr == ADR_CTRL);
    assign lim_wr  = wr_en & (wr_addr == ADR_LIMIT);
    assign out_wr  = wr_en & (wr_addr == ADR_OUT);

    runctl_gate #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DATA_W(DATA_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .lim_wr(lim_wr),
        .wr_data(wr_data), .start_ev(start_ev), .stop_ev(stop_ev),
        .halt(halt_w), .stop(stop_w), .bidir(bidir_w), .presc(presc_w),
        .limit(limit_w), .clr_req(clr_w), .run(run_w)
    );

    runctl_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_w), .clr(clr_w),
        .presc(presc_w), .tick(tick_w)
    );

    runctl_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_w), .clr(clr_w),
        .bidir(bidir_w), .limit(limit_w), .count(count), .dir_down(dir_down)
    );

    runctl_outreg #(.OUT_N(OUT_N), .DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .out_wr(out_wr), .halt(halt_w),
        .wr_data(wr_data), .out_pins(out_pins)
    );

    assign ev_allow = ~halt_w;

endmodule

// File: rtl/runctl_timer_chk.sv
module runctl_timer_chk #(
    parameter int CNT_W  = 16,
    parameter int OUT_N  = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              stop_ev,
    input logic              halt,
    input logic              stop,
    input logic [CNT_W-1:0]  count,
    input logic              dir_down,
    input logic [OUT_N-1:0]  out_pins
);

    logic ctrl_wr, clr_wr;
    assign ctrl_wr = wr_en && (wr_addr == 2'd0);
    assign clr_wr  = ctrl_wr && wr_data[3];

    // R2
    halted_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !clr_wr) |=> ($stable(count) && $stable(dir_down)));

    // R3
    stopped_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !clr_wr) |=> $stable(count));

    // R5
    halted_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && stop && !ctrl_wr) |=> stop);

    // R7
    out_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !halt |=> $stable(out_pins));

    // R9
    stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && stop_ev && !ctrl_wr) |=> stop);

    // R10
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (count == '0 && !dir_down));

endmodule

bind runctl_timer runctl_timer_chk #(.CNT_W(CNT_W), .OUT_N(OUT_N), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stop_ev(stop_ev), .halt(halt_w), .stop(stop_w), .count(count),
    .dir_down(dir_down), .out_pins(out_pins)
);

// File: tb/runctl_timer_bench.sv
`timescale 1ns/1ps
module runctl_timer_bench;

    localparam int CNT_W  = 16;
    localparam int PRE_W  = 8;
    localparam int OUT_N  = 4;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              start_ev = 1'b0;
    logic              stop_ev = 1'b0;
    logic [CNT_W-1:0]  count;
    logic              dir_down;
    logic              ev_allow;
    logic [OUT_N-1:0]  out_pins;

    always #2 clk = ~clk;

    runctl_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W), .OUT_N(OUT_N), .DATA_W(DATA_W)) u_runctl_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start_ev(start_ev), .stop_ev(stop_ev), .count(count), .dir_down(dir_down),
        .ev_allow(ev_allow), .out_pins(out_pins)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model state
    logic             m_halt, m_stop, m_bidir, m_dir;
    logic [PRE_W-1:0] m_pre, m_pc;
    logic [CNT_W-1:0] m_lim, m_cnt;
    logic [OUT_N-1:0] m_out;

    function automatic logic [DATA_W-1:0] mk_ctrl(bit h, bit s, bit b, bit c, logic [7:0] p);
        logic [DATA_W-1:0] v = '0;
        v[0] = h; v[1] = s; v[2] = b; v[3] = c; v[15:8] = p;
        return v;
    endfunction

    task automatic model_reset();
        m_halt = 1'b1; m_stop = 1'b0; m_bidir = 1'b0; m_dir = 1'b0;
        m_pre = '0; m_pc = '0; m_lim = '1; m_cnt = '0; m_out = '0;
    endtask

    task automatic model_step();
        bit ctw, clr, run, tick;
        ctw  = wr_en && wr_addr == 2'd0;
        clr  = ctw && wr_data[3];
        run  = !m_halt && !m_stop;
        tick = run && !clr && (m_pc >= m_pre);
        if (wr_en && wr_addr == 2'd2 && m_halt) m_out = wr_data[OUT_N-1:0];
        if (clr) begin
            m_cnt = '0; m_dir = 1'b0;
        end else if (tick) begin
            if (!m_bidir) begin
                m_dir = 1'b0;
                m_cnt = (m_cnt >= m_lim) ? '0 : m_cnt + 1'b1;
            end else if (!m_dir) begin
                if (m_cnt < m_lim) m_cnt = m_cnt + 1'b1;
                else if (m_cnt != 0) begin m_cnt = m_cnt - 1'b1; m_dir = 1'b1; end
            end else begin
                if (m_cnt != 0) m_cnt = m_cnt - 1'b1;
                else begin m_dir = 1'b0; m_cnt = (m_lim == 0) ? '0 : CNT_W'(1); end
            end
        end
        if (clr) m_pc = '0;
        else if (run) m_pc = (m_pc >= m_pre) ? '0 : m_pc + 1'b1;
        if (ctw) begin
            m_halt = wr_data[0]; m_stop = wr_data[1]; m_bidir = wr_data[2];
            m_pre = wr_data[15:8];
        end else if (!m_halt) begin
            if (stop_ev) m_stop = 1'b1;
            else if (start_ev) m_stop = 1'b0;
        end
        if (wr_en && wr_addr == 2'd1) m_lim = wr_data[CNT_W-1:0];
    endtask

    task automatic compare(string tag);
        n_cmp++;
        if (count !== m_cnt || dir_down !== m_dir || ev_allow !== !m_halt || out_pins !== m_out) begin
            n_bad++;
            $display("FAIL %s: got cnt=%0d dir=%0b allow=%0b out=%h, exp cnt=%0d dir=%0b allow=%0b out=%h",
                     tag, count, dir_down, ev_allow, out_pins, m_cnt, m_dir, !m_halt, m_out);
        end
    endtask

    // inputs are set at the falling edge; one call = one clock
    task automatic cyc(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        wr_en = 1'b0; start_ev = 1'b0; stop_ev = 1'b0;
        compare(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    task automatic wr(logic [1:0] a, logic [DATA_W-1:0] d, string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc(tag);
    endtask

    task automatic ev(bit st, bit sp, string tag);
        start_ev = st; stop_ev = sp;
        cyc(tag);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");
        idle(3, "R1");

        // R2 / R5: start events while halted do nothing
        ev(1, 0, "R5");
        ev(0, 1, "R2");
        idle(3, "R2");
        wr(2'd0, mk_ctrl(1, 1, 0, 0, 0), "R5");
        ev(1, 0, "R5");
        // R3: release halt with stop set -> waits
        wr(2'd0, mk_ctrl(0, 1, 0, 0, 0), "R3");
        idle(4, "R3");
        ev(1, 0, "R3");
        idle(5, "R3");

        // R7: output write while running is ignored
        wr(2'd2, 32'hF, "R7");
        idle(1, "R7");
        wr(2'd0, mk_ctrl(1, 0, 0, 0, 0), "R2");
        wr(2'd2, 32'hA, "R7");
        idle(2, "R7");

        // R6 / R4 / R10 / R11: limit 5, prescale 2, clear
        wr(2'd1, 32'd5, "R11");
        wr(2'd0, mk_ctrl(0, 0, 0, 1, 2), "R10");
        idle(24, "R4");
        wr(2'd0, mk_ctrl(0, 0, 0, 1, 0), "R10");
        idle(14, "R6");

        // R8: up/down, limit 3, then limit 0
        wr(2'd1, 32'd3, "R8");
        wr(2'd0, mk_ctrl(0, 0, 1, 1, 0), "R8");
        idle(16, "R8");
        wr(2'd1, 32'd0, "R8");
        wr(2'd0, mk_ctrl(0, 0, 1, 1, 0), "R8");
        idle(4, "R8");
        wr(2'd1, 32'd4, "R8");
        idle(6, "R8");

        // R9: event priorities
        ev(1, 1, "R9");
        idle(3, "R9");
        ev(1, 0, "R9");
        idle(2, "R9");
        stop_ev = 1'b1;
        wr(2'd0, mk_ctrl(0, 0, 1, 0, 0), "R9");
        idle(3, "R9");
        start_ev = 1'b1;
        wr(2'd0, mk_ctrl(0, 1, 1, 0, 0), "R9");
        idle(3, "R9");

        // R11: seeded random mix
        for (int k = 0; k < 6000; k++) begin
            int r;
            r = $urandom % 100;
            if (r < 3) begin
                wr_en = 1'b1; wr_addr = 2'd0;
                wr_data = mk_ctrl(($urandom % 5) == 0, $urandom % 2, $urandom % 2,
                                  ($urandom % 10) == 0, 8'($urandom % 4));
            end else if (r < 5) begin
                wr_en = 1'b1; wr_addr = 2'd1; wr_data = $urandom % 21;
            end else if (r < 8) begin
                wr_en = 1'b1; wr_addr = 2'd2; wr_data = $urandom;
            end
            start_ev = ($urandom % 100) < 5;
            stop_ev  = ($urandom % 100) < 3;
            cyc("R11");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got hang, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule